// File: doc/BRIEF.md
# Three-Register Push-Down Evaluation Datapath

This block is the arithmetic heart of a small stack machine. It holds exactly three data words, named A (top), B and C (bottom). They are never addressed by number. Every operation pushes onto them, pops them or rewrites them in place.

A decoder ahead of the block presents one operation code and one immediate operand per cycle, qualified by a valid strobe. The block updates all three words on the next rising clock edge. Signed overflow on the checked arithmetic operations raises a sticky error flag, which only reset clears.

The bottom word is never cleared by a pop; it keeps its value and is copied upward. Software must not rely on any stack contents after a control transfer. The block makes no promise there, and simply keeps whatever its last operation left.

Top module: `evstack_core`

## Requirements
- R1: While reset is held, and until the second rising clock edge after `rst_n` is released, A, B and C read zero and `err_flag` is low. Operations presented during that window are ignored.
- R2: Code 1 (push constant) loads the operand into A, moves the old A to B and the old B to C. The old C is discarded.
- R3: Code 2 (add constant) replaces A with A plus the operand and leaves B and C unchanged.
- R4: Code 3 (equals constant) replaces A with 1 if A equals the operand and with 0 otherwise. B and C are unchanged.
- R5: Code 4 (reverse) swaps A and B and leaves C unchanged.
- R6: The binary codes compute A := B op A, copy C into B and leave C unchanged. The codes are 5 = add, 6 = checked subtract (B minus A), 7 = wrapping subtract (B minus A) and 8 = multiply keeping the low word.
- R7: Code 9 (greater-than) is a binary operation that writes 1 into A when B is greater than A as two's-complement numbers and 0 otherwise, then pops as in R6.
- R8: Signed overflow in code 2, 5 or 6 sets `err_flag`, which then stays high until reset.
- R9: Codes 7 and 8 never set `err_flag`, whatever their operands.
- R10: With `op_valid` low, or with an unused code (0 or 10 to 15), A, B, C and `err_flag` all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| op_valid | input | 1 | Qualifies `op_code` and `operand` for this cycle |
| op_code | input | 4 | Operation selector, encoded as listed in the requirements |
| operand | input | DATA_W | Immediate constant for codes 1 to 3 |
| reg_a | output | DATA_W | Top of the stack |
| reg_b | output | DATA_W | Middle of the stack |
| reg_c | output | DATA_W | Bottom of the stack |
| err_flag | output | 1 | Sticky signed-overflow indicator |

## Verification
All three words are outputs, so a wrong shift, a lost or duplicated word, or a bad result shows at the ports on the very cycle after the faulty operation. A reference model compares every word on every step, so a fault is caught at once rather than when the word later reaches the top. A flag that is set wrongly or cleared wrongly is visible at once and stays wrong afterwards. Directed sequences drive each overflow boundary, the word dropped from the bottom, and the ignored window right after reset release. A long random sequence then mixes every code with both valid levels.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LDC  = 4'd1;
  localparam logic [OP_W-1:0] OPC_ADC  = 4'd2;
  localparam logic [OP_W-1:0] OPC_EQC  = 4'd3;
  localparam logic [OP_W-1:0] OPC_REV  = 4'd4;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'd5;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'd6;
  localparam logic [OP_W-1:0] OPC_DIFF = 4'd7;
  localparam logic [OP_W-1:0] OPC_PROD = 4'd8;
  localparam logic [OP_W-1:0] OPC_GT   = 4'd9;

  // How the three words move for one operation
  typedef enum logic [2:0] {
    MV_HOLD = 3'd0,
    MV_PUSH = 3'd1,
    MV_TOP  = 3'd2,
    MV_SWAP = 3'd3,
    MV_POP  = 3'd4
  } evs_move_e;
endpackage

// File: rtl/evs_rst_sync.sv
module evs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/evs_alu.sv
module evs_alu
  import evs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    imm,
  output evs_move_e       move,
  output logic [W-1:0]    res,
  output logic            ovf
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] sum_imm, sum_ba, dif_ba, prod_ba;
  logic         ovf_imm, ovf_add, ovf_sub, gt_ba;

  assign sum_imm = a + imm;
  assign sum_ba  = b + a;
  assign dif_ba  = b - a;
  assign prod_ba = b * a;
  assign ovf_imm = (a[MSB] == imm[MSB]) && (sum_imm[MSB] != a[MSB]);
  assign ovf_add = (a[MSB] == b[MSB]) && (sum_ba[MSB] != b[MSB]);
  assign ovf_sub = (a[MSB] != b[MSB]) && (dif_ba[MSB] != b[MSB]);
  assign gt_ba   = $signed(b) > $signed(a);

  always_comb begin
    move = MV_HOLD;
    res  = a;
    ovf  = 1'b0;
    if (valid) begin
      case (op)
        OPC_LDC:  begin move = MV_PUSH; res = imm; end
        OPC_ADC:  begin move = MV_TOP;  res = sum_imm; ovf = ovf_imm; end
        OPC_EQC:  begin move = MV_TOP;  res = (a == imm) ? ONE : '0; end
        OPC_REV:  begin move = MV_SWAP; res = b; end
        OPC_ADD:  begin move = MV_POP;  res = sum_ba; ovf = ovf_add; end
        OPC_SUB:  begin move = MV_POP;  res = dif_ba; ovf = ovf_sub; end
        OPC_DIFF: begin move = MV_POP;  res = dif_ba; end
        OPC_PROD: begin move = MV_POP;  res = prod_ba; end
        OPC_GT:   begin move = MV_POP;  res = gt_ba ? ONE : '0; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/evs_stack_regs.sv
module evs_stack_regs
  import evs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  evs_move_e    move,
  input  logic [W-1:0] res,
  input  logic         ovf,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] c_q,
  output logic         err_q
);
  logic [W-1:0] a_d, b_d, c_d;
  logic         ld_en;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    c_d = c_q;
    case (move)
      MV_PUSH: begin a_d = res; b_d = a_q; c_d = b_q; end
      MV_TOP:  begin a_d = res; end
      MV_SWAP: begin a_d = res; b_d = a_q; end
      MV_POP:  begin a_d = res; b_d = c_q; end
      default: ;
    endcase
  end

  assign ld_en = (move != MV_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (ld_en) begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_q <= 1'b0;
    else if (ovf) err_q <= 1'b1;
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/evstack_core.sv
module evstack_core
  import evs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] reg_c,
  output logic              err_flag
);
  logic         rst_sync_n;
  evs_move_e    move;
  logic [DATA_W-1:0] alu_res;
  logic         alu_ovf;

  evs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evs_alu #(.W(DATA_W)) u_alu (
    .valid (op_valid),
    .op    (op_code),
    .a     (reg_a),
    .b     (reg_b),
    .imm   (operand),
    .move  (move),
    .res   (alu_res),
    .ovf   (alu_ovf)
  );

  evs_stack_regs #(.W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .move  (move),
    .res   (alu_res),
    .ovf   (alu_ovf),
    .a_q   (reg_a),
    .b_q   (reg_b),
    .c_q   (reg_c),
    .err_q (err_flag)
  );

  logic is_pop;
  assign is_pop = op_valid && (op_code >= OPC_ADD) && (op_code <= OPC_GT);

  // R2
  push_shift_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OPC_LDC) |=>
      (reg_a == $past(operand) && reg_b == $past(reg_a) && reg_c == $past(reg_b)));

  // R3
  addc_below_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OPC_ADC) |=>
      (reg_b == $past(reg_b) && reg_c == $past(reg_c)));

  // R5
  swap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OPC_REV) |=>
      (reg_a == $past(reg_b) && reg_b == $past(reg_a) && reg_c == $past(reg_c)));

  // R6
  pop_move_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_pop |=> (reg_b == $past(reg_c) && reg_c == $past(reg_c)));

  // R9
  wrap_no_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (op_code == OPC_DIFF || op_code == OPC_PROD) && !err_flag) |=> !err_flag);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_c) && $stable(err_flag)));
endmodule

// File: tb/evstack_core_bench.sv
module evstack_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [31:0] operand;
  logic [31:0] reg_a, reg_b, reg_c;
  logic        err_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] ma, mb, mc;
  bit          merr;

  always #4 clk = ~clk;

  evstack_core #(.DATA_W(32)) u_evstack_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .err_flag(err_flag)
  );

  task automatic compare(input string req);
    checks++;
    if (reg_a !== ma || reg_b !== mb || reg_c !== mc || err_flag !== merr) begin
      errors++;
      $display("FAIL %s: got A=%h B=%h C=%h E=%b, want A=%h B=%h C=%h E=%b",
               req, reg_a, reg_b, reg_c, err_flag, ma, mb, mc, merr);
    end
  endtask

  function automatic bit out_of_range(input longint r);
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  // Caller sits at a negedge; returns at the following negedge.
  task automatic step(input bit v, input logic [3:0] op, input logic [31:0] x,
                      input string req);
    longint sa, sb, sx, r;
    logic [31:0] t;
    op_valid = v; op_code = op; operand = x;
    sa = longint'($signed(ma));
    sb = longint'($signed(mb));
    sx = longint'($signed(x));
    if (v) begin
      case (op)
        4'd1: begin mc = mb; mb = ma; ma = x; end
        4'd2: begin r = sa + sx; if (out_of_range(r)) merr = 1; ma = r[31:0]; end
        4'd3: ma = (ma == x) ? 32'd1 : 32'd0;
        4'd4: begin t = ma; ma = mb; mb = t; end
        4'd5: begin r = sb + sa; if (out_of_range(r)) merr = 1; ma = r[31:0]; mb = mc; end
        4'd6: begin r = sb - sa; if (out_of_range(r)) merr = 1; ma = r[31:0]; mb = mc; end
        4'd7: begin r = sb - sa; ma = r[31:0]; mb = mc; end
        4'd8: begin r = sb * sa; ma = r[31:0]; mb = mc; end
        4'd9: begin ma = (sb > sa) ? 32'd1 : 32'd0; mb = mc; end
        default: ;
      endcase
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; operand = '0;
    ma = '0; mb = '0; mc = '0; merr = 0;
    repeat (2) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    // An operation held across the two synchronizer edges must be ignored
    op_valid = 1'b1; op_code = 4'd1; operand = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    compare("R1 ignore during release");
    op_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1, 4'd1, 32'd5,  "R2 push");
    step(1, 4'd1, 32'd7,  "R2 push");
    step(1, 4'd1, 32'd9,  "R2 push");
    step(1, 4'd1, 32'd11, "R2 push drops bottom");
    step(1, 4'd5, 32'd0,  "R6 add");
    step(1, 4'd4, 32'd0,  "R5 reverse");
    step(1, 4'd6, 32'd0,  "R6 sub");
    step(1, 4'd7, 32'd0,  "R6 diff negative");
    step(1, 4'd9, 32'd0,  "R7 gt signed true");
    step(1, 4'd1, 32'd3,  "R2 push");
    step(1, 4'd9, 32'd0,  "R7 gt false");
    step(1, 4'd3, 32'd0,  "R4 eqc true");
    step(1, 4'd3, 32'd5,  "R4 eqc false");
    step(1, 4'd2, 32'd10, "R3 adc");
    step(1, 4'd1, 32'd6,  "R2 push");
    step(1, 4'd8, 32'd0,  "R6 prod");
    step(0, 4'd1, 32'h1234_5678, "R10 valid low");
    step(0, 4'd5, 32'h0, "R10 valid low");
    step(1, 4'd12, 32'h55, "R10 unused code");
    step(1, 4'd0, 32'h55,  "R10 code zero");
    step(1, 4'd1, 32'h8000_0000, "R2 push");
    step(1, 4'd1, 32'd1,         "R2 push");
    step(1, 4'd7, 32'd0,  "R9 diff wraps, no error");
    step(1, 4'd1, 32'h0001_0000, "R2 push");
    step(1, 4'd1, 32'h0001_0000, "R2 push");
    step(1, 4'd8, 32'd0,  "R9 prod wraps, no error");
    step(1, 4'd1, 32'h7FFF_FFFF, "R2 push");
    step(1, 4'd2, 32'd1,  "R8 adc overflow");
    step(1, 4'd1, 32'd1,  "R8 error stays");
    step(1, 4'd5, 32'd0,  "R8 error stays");
    do_reset();
    step(1, 4'd1, 32'h8000_0000, "R2 push");
    step(1, 4'd1, 32'd1,         "R2 push");
    step(1, 4'd6, 32'd0,  "R8 sub overflow");
    do_reset();
    step(1, 4'd1, 32'h7FFF_FFFF, "R2 push");
    step(1, 4'd1, 32'd1,         "R2 push");
    step(1, 4'd5, 32'd0,  "R8 add overflow");
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [31:0] x;
      logic [3:0]  o;
      bit          v;
      v = ($urandom % 8) != 0;
      o = 4'($urandom % 12);
      case ($urandom % 4)
        0: x = 32'h7FFF_FFFF;
        1: x = 32'h8000_0000;
        default: x = $urandom;
      endcase
      step(v, o, x, "R10 random mix (R2-R9)");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule